// File: doc/BRIEF.md
# Masked address-and-data watchpoint unit

This block watches every memory and I/O port access of a core as the access goes by, and raises a debug trap only when an access qualifies against one of four programmed watch slots. The check runs beside the access path and never stalls it. Watch slots 1 to 3 are plain watchpoints that cover 1, 2, 4 or 8 bytes. Watch slot 0 is extended. Any of its low twelve address bits can be marked don't-care, so it can cover a size-aligned window from one byte up to a 4 KiB page. It can also require the data carried by the access to equal a programmed value under a bit mask.

An access is presented as a 64-bit word address with eight byte enables and the data. The access is sampled on a clock edge. The trap output then pulses high for the following cycle. A sticky per-slot status vector records which slots fired. Software sets up the slots through a narrow write-only configuration port. That port accepts writes only while the privilege input is high. I/O port watching is further gated by a debug-extension enable input.

Top module: `wpu_top`

## Requirements
- R1: While reset is asserted, and after it is released, `trap_o` is 0, `hit_status_o` is 0 and every slot is disabled.
- R2: For slot 1, 2 or 3, the length code (0,1,2,3 → 1,2,4,8 bytes) selects a watch range whose start is the slot address rounded down to that length. The slot hits when the word address matches and at least one enabled byte lane of the access falls inside the range.
- R3: Slot 0 ignores its length code. An address bit in [11:0] whose don't-care mask bit is 1 is not compared. All other address bits must match exactly, and at least one enabled byte lane must satisfy the low-bit compare.
- R4: When control bit 5 of slot 0 is set, slot 0 also requires ((data XOR compare) AND mask) = 0. Mask bits of byte lanes whose byte enable is 0 count as don't-care.
- R5: Control bits [2:1] select the access kind: 0 matches memory writes only, 1 matches memory reads and writes, 2 matches I/O accesses only, and 3 never matches. Memory kinds never match I/O accesses.
- R6: An I/O access never hits while `io_dbg_en_i` is 0.
- R7: A slot whose control bit 0 is 0 never hits. A cycle with `acc_valid_i` low never hits.
- R8: `trap_o` is high for exactly the one cycle after the edge that sampled a hitting access. Several slots hitting the same access give that one pulse.
- R9: Each hit sets the slot's bit in `hit_status_o` on the same edge as the trap. The bit stays set until a write to the clear register (address 15) with a 1 in that bit position. If a hit and a clear meet on the same edge, the bit ends up set.
- R10: Configuration writes, including clear writes, have no effect while `priv_i` is 0.
- R11: Register map by `cfg_addr_i`:
  - 0–3: slot address.
  - 4–7: slot control, with bit 0 enable, bits [2:1] kind, bits [4:3] length and bit 5 data compare.
  - 8: slot 0 don't-care mask [11:0].
  - 9/10: compare value low/high 32 bits.
  - 11/12: data mask low/high 32 bits.
  - 15: status clear.

  A write is used by accesses sampled from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| priv_i | input | 1 | Privileged mode; configuration writes allowed only when high |
| io_dbg_en_i | input | 1 | Debug-extension enable; gates all I/O watching |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| acc_valid_i | input | 1 | An access is presented this cycle |
| acc_io_i | input | 1 | Access targets the I/O port space |
| acc_wr_i | input | 1 | Access is a write |
| acc_word_i | input | 29 | Byte address bits [31:3] of the access |
| acc_be_i | input | 8 | Byte-lane enables of the access |
| acc_data_i | input | 64 | Data carried by the access |
| trap_o | output | 1 | Debug trap pulse |
| hit_status_o | output | 4 | Sticky per-slot hit record |

## Verification
Any corrupted slot setting, such as a wrong rounded range, a lost don't-care bit or a stale compare value, shows up as a wrong `trap_o` in the cycle right after the first access that touches the affected bytes. It also leaves a wrong bit in `hit_status_o` that persists until a clear. A status bit that drops without a clear, or a trap with no access behind it, is visible on the very next edge. The bench therefore compares both outputs against a behavioural model on every clock. It places accesses on range edges, single byte lanes, masked-off data lanes and the I/O gate.

// File: rtl/wpu_pkg.sv
package wpu_pkg;
  localparam int WP_SLOTS   = 4;
  localparam int WP_AW      = 32;
  localparam int WP_DW      = 64;
  localparam int WP_LANES   = WP_DW / 8;
  localparam int WP_LANE_W  = $clog2(WP_LANES);
  localparam int WP_DC_W    = 12;
  localparam int WP_CFG_AW  = 4;
  localparam int WP_CFG_DW  = 32;
  localparam int WP_DWORDS  = WP_DW / WP_CFG_DW;
  localparam int WP_RST_STG = 2;

  localparam int CFG_ADDR_BASE  = 0;
  localparam int CFG_CTRL_BASE  = 4;
  localparam int CFG_DCMASK     = 8;
  localparam int CFG_CMP_BASE   = 9;
  localparam int CFG_DMASK_BASE = 11;
  localparam int CFG_CLEAR      = 15;

  typedef enum logic [1:0] {
    KIND_WR   = 2'd0,
    KIND_RW   = 2'd1,
    KIND_IO   = 2'd2,
    KIND_NONE = 2'd3
  } wp_kind_e;

  typedef struct packed {
    logic     dmatch_en;
    logic [1:0] len;
    wp_kind_e kind;
    logic     en;
  } wp_ctrl_t;

  localparam int WP_CTRL_W = $bits(wp_ctrl_t);

  function automatic logic wp_kind_ok(wp_kind_e k, logic is_io, logic is_wr, logic io_en);
    logic ok;
    case (k)
      KIND_WR: ok = !is_io && is_wr;
      KIND_RW: ok = !is_io;
      KIND_IO: ok = is_io && io_en;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/wpu_cfg.sv
module wpu_cfg
  import wpu_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              priv_i,
  input  logic                              we_i,
  input  logic [WP_CFG_AW-1:0]              addr_i,
  input  logic [WP_CFG_DW-1:0]              wdata_i,
  output logic [WP_SLOTS-1:0][WP_AW-1:0]    slot_addr_o,
  output wp_ctrl_t [WP_SLOTS-1:0]           slot_ctrl_o,
  output logic [WP_DC_W-1:0]                dc_mask_o,
  output logic [WP_DW-1:0]                  cmp_o,
  output logic [WP_DW-1:0]                  dmask_o,
  output logic [WP_SLOTS-1:0]               clr_o
);
  logic                           wr_ok;
  logic [WP_SLOTS-1:0][WP_AW-1:0] addr_q, addr_d;
  wp_ctrl_t [WP_SLOTS-1:0]        ctrl_q, ctrl_d;
  logic [WP_DC_W-1:0]             dc_q, dc_d;
  logic [WP_DW-1:0]               cmp_q, cmp_d;
  logic [WP_DW-1:0]               dmask_q, dmask_d;

  assign wr_ok = we_i & priv_i;

  always_comb begin
    addr_d  = addr_q;
    ctrl_d  = ctrl_q;
    dc_d    = dc_q;
    cmp_d   = cmp_q;
    dmask_d = dmask_q;
    clr_o   = '0;
    for (int s = 0; s < WP_SLOTS; s++) begin
      if (addr_i == WP_CFG_AW'(CFG_ADDR_BASE + s)) addr_d[s] = WP_AW'(wdata_i);
      if (addr_i == WP_CFG_AW'(CFG_CTRL_BASE + s)) ctrl_d[s] = wdata_i[WP_CTRL_W-1:0];
    end
    if (addr_i == WP_CFG_AW'(CFG_DCMASK)) dc_d = wdata_i[WP_DC_W-1:0];
    for (int w = 0; w < WP_DWORDS; w++) begin
      if (addr_i == WP_CFG_AW'(CFG_CMP_BASE + w))
        cmp_d[w*WP_CFG_DW +: WP_CFG_DW] = wdata_i;
      if (addr_i == WP_CFG_AW'(CFG_DMASK_BASE + w))
        dmask_d[w*WP_CFG_DW +: WP_CFG_DW] = wdata_i;
    end
    if (wr_ok && addr_i == WP_CFG_AW'(CFG_CLEAR)) clr_o = wdata_i[WP_SLOTS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      ctrl_q  <= '0;
      dc_q    <= '0;
      cmp_q   <= '0;
      dmask_q <= '0;
    end else if (wr_ok) begin
      addr_q  <= addr_d;
      ctrl_q  <= ctrl_d;
      dc_q    <= dc_d;
      cmp_q   <= cmp_d;
      dmask_q <= dmask_d;
    end
  end

  assign slot_addr_o = addr_q;
  assign slot_ctrl_o = ctrl_q;
  assign dc_mask_o   = dc_q;
  assign cmp_o       = cmp_q;
  assign dmask_o     = dmask_q;

  // R10: an unprivileged write leaves every setting untouched
  a_r10_locked_unpriv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !priv_i) |=> ($stable(addr_q) && $stable(ctrl_q) && $stable(dc_q)
                           && $stable(cmp_q) && $stable(dmask_q)));
endmodule

// File: rtl/wpu_match_plain.sv
module wpu_match_plain
  import wpu_pkg::*;
(
  input  logic [WP_AW-1:0]          slot_addr_i,
  input  wp_ctrl_t                  ctrl_i,
  input  logic                      acc_io_i,
  input  logic                      acc_wr_i,
  input  logic                      io_en_i,
  input  logic [WP_AW-1:WP_LANE_W]  acc_word_i,
  input  logic [WP_LANES-1:0]       acc_be_i,
  output logic                      hit_o
);
  logic [WP_LANE_W:0]    span;
  logic [WP_LANE_W-1:0]  base;
  logic [WP_LANES-1:0]   lane_sel;
  logic                  word_hit;
  logic                  unused_dmatch;

  assign unused_dmatch = ctrl_i.dmatch_en;
  assign span = (WP_LANE_W+1)'(1) << ctrl_i.len;
  assign base = slot_addr_i[WP_LANE_W-1:0] & ~(WP_LANE_W'(span - 1'b1));

  for (genvar l = 0; l < WP_LANES; l++) begin : g_lane
    assign lane_sel[l] = ((WP_LANE_W+1)'(l) >= {1'b0, base}) &&
                         ((WP_LANE_W+1)'(l) <  ({1'b0, base} + span));
  end

  assign word_hit = (acc_word_i == slot_addr_i[WP_AW-1:WP_LANE_W]);
  assign hit_o = ctrl_i.en && wp_kind_ok(ctrl_i.kind, acc_io_i, acc_wr_i, io_en_i)
                 && word_hit && (|(lane_sel & acc_be_i));
endmodule

// File: rtl/wpu_match_ext.sv
module wpu_match_ext
  import wpu_pkg::*;
(
  input  logic [WP_AW-1:0]          slot_addr_i,
  input  wp_ctrl_t                  ctrl_i,
  input  logic [WP_DC_W-1:0]        dc_mask_i,
  input  logic [WP_DW-1:0]          cmp_i,
  input  logic [WP_DW-1:0]          dmask_i,
  input  logic                      acc_io_i,
  input  logic                      acc_wr_i,
  input  logic                      io_en_i,
  input  logic [WP_AW-1:WP_LANE_W]  acc_word_i,
  input  logic [WP_LANES-1:0]       acc_be_i,
  input  logic [WP_DW-1:0]          acc_data_i,
  output logic                      hit_o
);
  logic [WP_AW-1:0]          dc_full;
  logic [WP_AW-1:WP_LANE_W]  word_diff;
  logic [WP_LANES-1:0]       lane_sel;
  logic [WP_DW-1:0]          eff_mask;
  logic                      data_ok;
  logic [1:0]                unused_len;

  assign unused_len = ctrl_i.len;
  assign dc_full    = WP_AW'(dc_mask_i);
  assign word_diff  = (acc_word_i ^ slot_addr_i[WP_AW-1:WP_LANE_W]) & ~dc_full[WP_AW-1:WP_LANE_W];

  for (genvar l = 0; l < WP_LANES; l++) begin : g_lane
    assign lane_sel[l] = ((WP_LANE_W'(l) ^ slot_addr_i[WP_LANE_W-1:0])
                          & ~dc_full[WP_LANE_W-1:0]) == '0;
    assign eff_mask[8*l +: 8] = dmask_i[8*l +: 8] & {8{acc_be_i[l]}};
  end

  assign data_ok = !ctrl_i.dmatch_en || (((acc_data_i ^ cmp_i) & eff_mask) == '0);
  assign hit_o = ctrl_i.en && wp_kind_ok(ctrl_i.kind, acc_io_i, acc_wr_i, io_en_i)
                 && (word_diff == '0) && (|(lane_sel & acc_be_i)) && data_ok;
endmodule

// File: rtl/wpu_trap.sv
module wpu_trap
  import wpu_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                acc_valid_i,
  input  logic [WP_SLOTS-1:0] hit_i,
  input  logic [WP_SLOTS-1:0] clr_i,
  output logic                trap_o,
  output logic [WP_SLOTS-1:0] status_o
);
  logic [WP_SLOTS-1:0] hit_v, status_d, status_q;
  logic                trap_d, trap_q, status_en;

  always_comb begin
    hit_v     = hit_i & {WP_SLOTS{acc_valid_i}};
    trap_d    = |hit_v;
    status_en = acc_valid_i || (|clr_i);
    status_d  = (status_q & ~clr_i) | hit_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trap_q   <= 1'b0;
      status_q <= '0;
    end else begin
      trap_q <= trap_d;
      if (status_en) status_q <= status_d;
    end
  end

  assign trap_o   = trap_q;
  assign status_o = status_q;

  // R9: a status bit only falls after a clear request
  a_r9_status_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(status_q) & ~status_q)) |-> $past(|clr_i));
  // R8: every trap pulse stems from a presented access
  a_r8_trap_from_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q |-> $past(acc_valid_i));
  // R8: a trap always leaves a record in the status vector
  a_r8_trap_recorded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_q |-> (status_q != '0));
endmodule

// File: rtl/wpu_top.sv
module wpu_top
  import wpu_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      priv_i,
  input  logic                      io_dbg_en_i,
  input  logic                      cfg_we_i,
  input  logic [WP_CFG_AW-1:0]      cfg_addr_i,
  input  logic [WP_CFG_DW-1:0]      cfg_wdata_i,
  input  logic                      acc_valid_i,
  input  logic                      acc_io_i,
  input  logic                      acc_wr_i,
  input  logic [WP_AW-1:WP_LANE_W]  acc_word_i,
  input  logic [WP_LANES-1:0]       acc_be_i,
  input  logic [WP_DW-1:0]          acc_data_i,
  output logic                      trap_o,
  output logic [WP_SLOTS-1:0]       hit_status_o
);
  logic [WP_RST_STG-1:0]          rst_sync_q;
  logic                           rst_sync_n;
  logic [WP_SLOTS-1:0][WP_AW-1:0] slot_addr;
  wp_ctrl_t [WP_SLOTS-1:0]        slot_ctrl;
  logic [WP_DC_W-1:0]             dc_mask;
  logic [WP_DW-1:0]               cmp_val, dmask;
  logic [WP_SLOTS-1:0]            clr, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[WP_RST_STG-2:0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[WP_RST_STG-1];

  wpu_cfg i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .priv_i      (priv_i),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i),
    .slot_addr_o (slot_addr),
    .slot_ctrl_o (slot_ctrl),
    .dc_mask_o   (dc_mask),
    .cmp_o       (cmp_val),
    .dmask_o     (dmask),
    .clr_o       (clr)
  );

  for (genvar s = 0; s < WP_SLOTS; s++) begin : g_slot
    if (s == 0) begin : g_ext
      wpu_match_ext i_match (
        .slot_addr_i (slot_addr[s]),
        .ctrl_i      (slot_ctrl[s]),
        .dc_mask_i   (dc_mask),
        .cmp_i       (cmp_val),
        .dmask_i     (dmask),
        .acc_io_i    (acc_io_i),
        .acc_wr_i    (acc_wr_i),
        .io_en_i     (io_dbg_en_i),
        .acc_word_i  (acc_word_i),
        .acc_be_i    (acc_be_i),
        .acc_data_i  (acc_data_i),
        .hit_o       (hit[s])
      );
    end else begin : g_plain
      wpu_match_plain i_match (
        .slot_addr_i (slot_addr[s]),
        .ctrl_i      (slot_ctrl[s]),
        .acc_io_i    (acc_io_i),
        .acc_wr_i    (acc_wr_i),
        .io_en_i     (io_dbg_en_i),
        .acc_word_i  (acc_word_i),
        .acc_be_i    (acc_be_i),
        .hit_o       (hit[s])
      );
    end
  end

  wpu_trap i_trap (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .acc_valid_i (acc_valid_i),
    .hit_i       (hit),
    .clr_i       (clr),
    .trap_o      (trap_o),
    .status_o    (hit_status_o)
  );

  // R6: I/O accesses stay silent while debug extensions are off
  a_r6_io_gated: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (acc_valid_i && acc_io_i && !io_dbg_en_i) |=> !trap_o);
  // R7: no access presented, no trap
  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !acc_valid_i |=> !trap_o);
endmodule

// File: tb/test_wpu_top.sv
`timescale 1ns/1ps
module test_wpu_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        priv, io_en, cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        a_valid, a_io, a_wr;
  logic [31:3] a_word;
  logic [7:0]  a_be;
  logic [63:0] a_data;
  logic        trap;
  logic [3:0]  status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  string cur_req = "R1";

  // behavioural reference state
  longint unsigned m_addr [4];
  bit              m_en   [4];
  int              m_kind [4];
  int              m_len  [4];
  bit              m_dm;
  longint unsigned m_dc, m_cmp, m_dmask;
  bit              exp_trap;
  bit [3:0]        exp_status;

  always #2.5 clk = ~clk;

  wpu_top i_wpu_top (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv), .io_dbg_en_i(io_en),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .acc_valid_i(a_valid), .acc_io_i(a_io), .acc_wr_i(a_wr),
    .acc_word_i(a_word), .acc_be_i(a_be), .acc_data_i(a_data),
    .trap_o(trap), .hit_status_o(status)
  );

  function automatic bit [3:0] ref_hits();
    bit [3:0] h = '0;
    for (int s = 0; s < 4; s++) begin
      bit kind_ok, any_lane, data_ok;
      any_lane = 0;
      data_ok  = 1;
      case (m_kind[s])
        0: kind_ok = !a_io && a_wr;
        1: kind_ok = !a_io;
        2: kind_ok = a_io && io_en;
        default: kind_ok = 0;
      endcase
      if (m_en[s] && kind_ok) begin
        for (int l = 0; l < 8; l++) begin
          if (a_be[l]) begin
            longint unsigned ba = (longint'(a_word) << 3) + l;
            if (s == 0) begin
              if ((((ba ^ m_addr[0]) & ~m_dc) & 64'hFFFF_FFFF) == 0) any_lane = 1;
              if (m_dm && ((((a_data ^ m_cmp) & m_dmask) >> (8*l)) & 64'hFF) != 0) data_ok = 0;
            end else begin
              longint unsigned len  = 64'd1 << m_len[s];
              longint unsigned base = m_addr[s] - (m_addr[s] % len);
              if (ba >= base && ba < base + len) any_lane = 1;
            end
          end
        end
        if (any_lane && data_ok) h[s] = 1;
      end
    end
    return h;
  endfunction

  task automatic model_step();
    bit [3:0] h, clr;
    if (!rst_n) begin
      exp_trap = 0; exp_status = 0; m_dm = 0; m_dc = 0; m_cmp = 0; m_dmask = 0;
      for (int s = 0; s < 4; s++) begin m_addr[s] = 0; m_en[s] = 0; m_kind[s] = 0; m_len[s] = 0; end
      return;
    end
    h   = a_valid ? ref_hits() : 4'b0;
    clr = (cfg_we && priv && cfg_addr == 15) ? cfg_wdata[3:0] : 4'b0;
    exp_trap   = |h;
    exp_status = (exp_status & ~clr) | h;
    if (cfg_we && priv) begin
      case (cfg_addr)
        0, 1, 2, 3: m_addr[cfg_addr] = cfg_wdata;
        4, 5, 6, 7: begin
          m_en[cfg_addr-4]   = cfg_wdata[0];
          m_kind[cfg_addr-4] = cfg_wdata[2:1];
          m_len[cfg_addr-4]  = cfg_wdata[4:3];
          if (cfg_addr == 4) m_dm = cfg_wdata[5];
        end
        8:  m_dc = cfg_wdata[11:0];
        9:  m_cmp[31:0] = cfg_wdata;
        10: m_cmp[63:32] = cfg_wdata;
        11: m_dmask[31:0] = cfg_wdata;
        12: m_dmask[63:32] = cfg_wdata;
        default: ;
      endcase
    end
  endtask

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(cur_req, "model trap", trap, exp_trap);
    chk(cur_req, "model status", status, exp_status);
  endtask

  task automatic idle_inputs();
    cfg_we = 0; a_valid = 0; a_io = 0; a_wr = 0; a_be = 0; a_data = 0; a_word = 0;
  endtask

  task automatic cfg(input logic [3:0] ad, input logic [31:0] d, input bit p = 1);
    cfg_we = 1; cfg_addr = ad; cfg_wdata = d; priv = p;
    tick();
    cfg_we = 0; priv = 1;
  endtask

  task automatic acc(input bit io, input bit wr, input logic [31:3] w,
                     input logic [7:0] be, input logic [63:0] d = 64'h0);
    a_valid = 1; a_io = io; a_wr = wr; a_word = w; a_be = be; a_data = d;
    tick();
    a_valid = 0;
  endtask

  initial begin
    rst_n = 0; priv = 1; io_en = 0; cfg_addr = 0; cfg_wdata = 0;
    idle_inputs();
    repeat (3) tick();
    // R1: outputs quiet in reset
    chk("R1", "trap in reset", trap, 0);
    chk("R1", "status in reset", status, 0);
    rst_n = 1;
    repeat (4) tick();
    chk("R1", "trap after reset", trap, 0);
    chk("R1", "status after reset", status, 0);

    // R10: unprivileged setup must not arm slot 1
    cur_req = "R10";
    cfg(4'd1, 32'h1004, 0);
    cfg(4'd5, 32'd19, 0);
    acc(0, 0, 29'h200, 8'h10);
    chk("R10", "unpriv config armed slot", trap, 0);

    // R2: slot 1, 4 bytes at 0x1004 (R11 map: addr 1, ctrl 5)
    cur_req = "R2";
    cfg(4'd1, 32'h1004);
    cfg(4'd5, 32'd19);
    acc(0, 0, 29'h200, 8'h10);
    chk("R2", "byte 0x1004 hit", trap, 1);
    chk("R9", "slot1 status", status, 4'b0010);
    acc(0, 0, 29'h200, 8'h08);
    chk("R2", "byte 0x1003 outside", trap, 0);
    chk("R9", "status sticky", status, 4'b0010);
    acc(0, 1, 29'h200, 8'h80);
    chk("R2", "byte 0x1007 inside", trap, 1);

    // R10 / R9: clear only when privileged
    cur_req = "R9";
    cfg(4'd15, 32'hF, 0);
    chk("R10", "unpriv clear ignored", status, 4'b0010);
    cfg(4'd15, 32'h2);
    chk("R9", "clear slot1", status, 4'b0000);

    // R2: 8-byte length rounds 0x2005 down to 0x2000
    cur_req = "R2";
    cfg(4'd2, 32'h2005);
    cfg(4'd6, 32'd27);
    acc(0, 0, 29'h400, 8'h01);
    chk("R2", "len8 aligned down", trap, 1);
    chk("R2", "slot2 status", status, 4'b0100);
    // R5: slot 3 write-only, one byte at 0x3006
    cur_req = "R5";
    cfg(4'd3, 32'h3006);
    cfg(4'd7, 32'd1);
    acc(0, 0, 29'h600, 8'h40);
    chk("R5", "read on write-only slot", trap, 0);
    acc(0, 1, 29'h600, 8'h40);
    chk("R5", "write on write-only slot", trap, 1);
    chk("R5", "slots 2 and 3 recorded", status, 4'b1100);
    acc(0, 1, 29'h600, 8'h80);
    chk("R2", "len1 neighbour byte", trap, 0);
    cfg(4'd15, 32'hF);

    // R3: slot 0 window 0x4000..0x40FF
    cur_req = "R3";
    cfg(4'd0, 32'h4000);
    cfg(4'd8, 32'h0FF);
    cfg(4'd4, 32'd3);
    acc(0, 0, 29'h81F, 8'h80);
    chk("R3", "last byte of window", trap, 1);
    chk("R3", "slot0 status", status, 4'b0001);
    acc(0, 0, 29'h820, 8'h01);
    chk("R3", "first byte past window", trap, 0);
    acc(0, 0, 29'h2800, 8'h01);
    chk("R3", "upper bit differs", trap, 0);
    cfg(4'd15, 32'hF);

    // R4: data compare on lane 0 only
    cur_req = "R4";
    cfg(4'd9, 32'hAB);
    cfg(4'd11, 32'hFF);
    cfg(4'd4, 32'd35);
    acc(0, 1, 29'h800, 8'h01, 64'h55AB);
    chk("R4", "data equal", trap, 1);
    acc(0, 1, 29'h800, 8'h01, 64'h00AC);
    chk("R4", "data differs", trap, 0);
    acc(0, 1, 29'h800, 8'h02, 64'h00AC);
    chk("R4", "uncarried lane is don't-care", trap, 1);
    cfg(4'd15, 32'hF);

    // R6 / R5: I/O kind on slot 0
    cur_req = "R6";
    cfg(4'd4, 32'd5);
    acc(1, 0, 29'h800, 8'h01);
    chk("R6", "io with extensions off", trap, 0);
    io_en = 1;
    acc(1, 0, 29'h800, 8'h01);
    chk("R6", "io with extensions on", trap, 1);
    cur_req = "R5";
    acc(0, 0, 29'h800, 8'h01);
    chk("R5", "memory access on io slot", trap, 0);
    acc(1, 0, 29'h200, 8'h10);
    chk("R5", "io access on memory slot", trap, 0);
    cfg(4'd15, 32'hF);

    // R8: two slots on one access
    cur_req = "R8";
    cfg(4'd2, 32'h1000);
    acc(0, 0, 29'h200, 8'h10);
    chk("R8", "multi hit single trap", trap, 1);
    chk("R8", "both slots recorded", status, 4'b0110);
    tick();
    chk("R8", "trap lasts one cycle", trap, 0);
    cfg(4'd15, 32'hF);

    // R7: enable bit and valid
    cur_req = "R7";
    cfg(4'd5, 32'd18);
    acc(0, 0, 29'h200, 8'h10);
    chk("R7", "disabled slot1 silent", status, 4'b0100);
    cfg(4'd15, 32'hF);
    cfg(4'd6, 32'd31);
    acc(0, 0, 29'h200, 8'h10);
    chk("R5", "kind 3 never hits", trap, 0);
    a_valid = 0; a_word = 29'h200; a_be = 8'h10;
    tick();
    chk("R7", "no valid no trap", trap, 0);

    // R9: hit and clear on the same edge
    cur_req = "R9";
    cfg(4'd6, 32'd27);
    cfg_we = 1; cfg_addr = 15; cfg_wdata = 32'h4;
    a_valid = 1; a_io = 0; a_wr = 0; a_word = 29'h200; a_be = 8'h10;
    tick();
    idle_inputs();
    chk("R9", "set wins over clear", status, 4'b0100);

    // R11: write and access on the same edge use the old setting
    cur_req = "R11";
    cfg_we = 1; cfg_addr = 6; cfg_wdata = 32'd26;
    a_valid = 1; a_word = 29'h200; a_be = 8'h10;
    tick();
    idle_inputs();
    chk("R11", "old setting on write edge", trap, 1);
    acc(0, 0, 29'h200, 8'h10);
    chk("R11", "new setting afterwards", trap, 0);

    // R8: mixed traffic against the model
    cur_req = "R8";
    cfg(4'd6, 32'd27);
    cfg(4'd5, 32'd19);
    cfg(4'd4, 32'd35);
    for (int i = 0; i < 400; i++) begin
      logic [31:3] pool [5] = '{29'h200, 29'h400, 29'h600, 29'h800, 29'h81F};
      a_valid = ($urandom_range(0, 3) != 0);
      a_io    = ($urandom_range(0, 3) == 0);
      a_wr    = $urandom_range(0, 1);
      io_en   = $urandom_range(0, 1);
      a_word  = pool[$urandom_range(0, 4)];
      a_be    = 8'($urandom);
      a_data  = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 1) a_data[7:0] = 8'hAB;
      cfg_we  = ($urandom_range(0, 7) == 0);
      cfg_addr = 4'd15;
      cfg_wdata = 32'($urandom_range(0, 15));
      tick();
    end
    idle_inputs();
    tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule